// File: doc/BRIEF.md
# Function Level Reset Handshake Controller

This block runs on the application side of a PCI Express endpoint. It turns function-level reset requests from the link core into drain operations and then into completion pulses back to the core. Each of the eight physical functions raises its own request line. That line stays high until the block returns a completion for that function. A virtual-function request arrives instead as a one-cycle strobe, tagged with the parent physical function and an 11-bit offset.

Virtual-function strobes are stored in an eight-entry first-in first-out queue. The controller serves one function at a time. It presents the function on a request/acknowledge drain port and holds the request until the transaction logic acknowledges that nothing of that function is left outstanding. It then returns the matching completion pulse. Completion strobes for virtual functions are kept at least four cycles apart. A per-function busy vector shows which physical functions are still in reset.

Top module: `flr_handshake_ctrl`

## Requirements
- R1: While reset (active high, synchronous) is asserted and in the first cycle after it, drain_req, pf_done, vf_done and q_overflow are low and the queue is empty.
- R2: When the controller is idle and any physical function is pending (its request is high and it has not been completed since the request rose), it drains the lowest-numbered pending function first. A pending physical function is always chosen before a queued virtual function.
- R3: Virtual-function strobes are drained in arrival order. drain_pf and drain_off equal the parent number and offset sampled with the strobe, and drain_is_vf is 1 for a virtual function and 0 for a physical one.
- R4: drain_req stays high, with stable target fields, until drain_ack is sampled high. It is low in the following cycle.
- R5: Acknowledging a physical-function drain makes pf_done show exactly that function's bit (bit n for function n) in the next cycle, for one cycle. A request held high afterwards yields no further pulse.
- R6: Acknowledging a virtual-function drain produces one vf_done pulse carrying the drained parent number and offset. The pulse comes in cycle max(A+1, P+4), where A is the acknowledge cycle and P the previous vf_done cycle.
- R7: Two vf_done pulses are never less than 4 cycles apart.
- R8: pf_busy bit n is high exactly when request n is high and function n has not yet been completed since that request rose.
- R9: The queue holds 8 entries. A strobe that arrives while 8 entries are held and no entry leaves in that cycle is dropped and sets q_overflow, which stays high until reset. A strobe that arrives when the queue is full but an entry leaves in the same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_flr_lvl | input | 8 | Held reset request, one bit per physical function |
| vf_flr_pulse | input | 1 | One-cycle virtual-function reset strobe |
| vf_flr_pf | input | 3 | Parent function of the strobed request |
| vf_flr_off | input | 11 | Virtual-function offset of the strobed request |
| drain_req | output | 1 | Ask transaction logic to quiesce the target |
| drain_is_vf | output | 1 | Target is a virtual function |
| drain_pf | output | 3 | Target physical or parent function number |
| drain_off | output | 11 | Target virtual-function offset |
| drain_ack | input | 1 | Target has no outstanding transactions |
| pf_done | output | 8 | One-cycle completion, one bit per physical function |
| vf_done | output | 1 | One-cycle virtual-function completion |
| vf_done_pf | output | 3 | Parent function of the completion |
| vf_done_off | output | 11 | Offset of the completion |
| pf_busy | output | 8 | Physical function still in reset |
| q_overflow | output | 1 | Sticky queue overflow flag |

## Verification
The bench targets a request that stays high after its completion: a design that does not remember completed functions would drain that function again and send a second pf_done. It also acknowledges virtual-function drains right after an earlier completion. A pacing counter that is off by one would then pulse vf_done a cycle early or late against the exact cycle from R6. A burst of strobes with acknowledges withheld fills the queue past its depth: a design that wrapped its pointers silently would drain entries out of order or never raise q_overflow. Requests are also raised in several physical functions at once while virtual entries wait, so a wrong priority shows up as a mismatched drain target.

// File: rtl/flr_handshake_ctrl.sv
module flr_handshake_ctrl #(
  parameter int NUM_PF = 8,
  parameter int PF_W   = $clog2(NUM_PF),
  parameter int VF_W   = 11,
  parameter int QDEPTH = 8,
  parameter int GAP    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PF-1:0] pf_flr_lvl,
  input  logic              vf_flr_pulse,
  input  logic [PF_W-1:0]   vf_flr_pf,
  input  logic [VF_W-1:0]   vf_flr_off,
  output logic              drain_req,
  output logic              drain_is_vf,
  output logic [PF_W-1:0]   drain_pf,
  output logic [VF_W-1:0]   drain_off,
  input  logic              drain_ack,
  output logic [NUM_PF-1:0] pf_done,
  output logic              vf_done,
  output logic [PF_W-1:0]   vf_done_pf,
  output logic [VF_W-1:0]   vf_done_off,
  output logic [NUM_PF-1:0] pf_busy,
  output logic              q_overflow
);
  localparam int QA_W  = $clog2(QDEPTH);
  localparam int QC_W  = $clog2(QDEPTH + 1);
  localparam int GC_W  = $clog2(GAP + 1);
  localparam int ENT_W = PF_W + VF_W;

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_VHOLD} state_t;
  state_t state;

  logic [ENT_W-1:0]  q_mem [QDEPTH];
  logic [QA_W-1:0]   wr_ptr, rd_ptr;
  logic [QC_W-1:0]   q_cnt;
  logic [NUM_PF-1:0] served, pend, tgt_hot;
  logic [PF_W-1:0]   pick, tgt_pf;
  logic [VF_W-1:0]   tgt_off;
  logic              tgt_vf;
  logic [GC_W-1:0]   gap_cnt;
  logic              start_pf, start_vf, push_ok, fire_pf, fire_vf, gap_ok;

  function automatic logic [QA_W-1:0] nxt(input logic [QA_W-1:0] p);
    return (p == QA_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pend     = pf_flr_lvl & ~served;
  assign pf_busy  = pend;
  assign start_pf = (state == S_IDLE) && (|pend);
  assign start_vf = (state == S_IDLE) && !(|pend) && (q_cnt != '0);
  assign push_ok  = vf_flr_pulse && ((q_cnt < QC_W'(QDEPTH)) || start_vf);
  assign gap_ok   = (gap_cnt == '0);
  assign fire_pf  = (state == S_DRAIN) && drain_ack && !tgt_vf;
  assign fire_vf  = ((state == S_DRAIN) && drain_ack && tgt_vf && gap_ok) ||
                    ((state == S_VHOLD) && gap_ok);
  assign tgt_hot  = NUM_PF'(1) << tgt_pf;

  assign drain_req   = (state == S_DRAIN);
  assign drain_is_vf = tgt_vf;
  assign drain_pf    = tgt_pf;
  assign drain_off   = tgt_off;
  assign vf_done_pf  = tgt_pf;
  assign vf_done_off = tgt_off;

  always_comb begin
    pick = '0;
    for (int i = NUM_PF - 1; i >= 0; i--)
      if (pend[i]) pick = PF_W'(i);
  end

  always_ff @(posedge clk)
    if (push_ok) q_mem[wr_ptr] <= {vf_flr_pf, vf_flr_off};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      q_cnt      <= '0;
      served     <= '0;
      tgt_vf     <= 1'b0;
      tgt_pf     <= '0;
      tgt_off    <= '0;
      gap_cnt    <= '0;
      pf_done    <= '0;
      vf_done    <= 1'b0;
      q_overflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (start_vf) rd_ptr <= nxt(rd_ptr);
      q_cnt <= q_cnt + QC_W'(push_ok) - QC_W'(start_vf);
      if (vf_flr_pulse && !push_ok) q_overflow <= 1'b1;

      served  <= (served & pf_flr_lvl) | (fire_pf ? tgt_hot : '0);
      pf_done <= fire_pf ? tgt_hot : '0;
      vf_done <= fire_vf;
      gap_cnt <= fire_vf ? GC_W'(GAP - 1) : (gap_ok ? '0 : gap_cnt - 1'b1);

      case (state)
        S_IDLE:
          if (start_pf) begin
            tgt_vf  <= 1'b0;
            tgt_pf  <= pick;
            tgt_off <= '0;
            state   <= S_DRAIN;
          end else if (start_vf) begin
            tgt_vf            <= 1'b1;
            {tgt_pf, tgt_off} <= q_mem[rd_ptr];
            state             <= S_DRAIN;
          end
        S_DRAIN:
          if (drain_ack) state <= (tgt_vf && !gap_ok) ? S_VHOLD : S_IDLE;
        S_VHOLD:
          if (gap_ok) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [GC_W-1:0] since_vf;
  always_ff @(posedge clk)
    if (rst) since_vf <= GC_W'(GAP);
    else if (vf_done) since_vf <= GC_W'(1);
    else if (since_vf < GC_W'(GAP)) since_vf <= since_vf + 1'b1;

  a_r4_drain_hold: assert property (@(posedge clk) disable iff (rst)
    (drain_req && !drain_ack) |=> (drain_req && $stable(drain_pf) &&
                                   $stable(drain_off) && $stable(drain_is_vf)));
  a_r4_drain_drop: assert property (@(posedge clk) disable iff (rst)
    (drain_req && drain_ack) |=> !drain_req);
  a_r5_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(pf_done));
  a_r7_spacing: assert property (@(posedge clk) disable iff (rst)
    vf_done |-> (since_vf >= GC_W'(GAP)));
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    (pf_done & pf_busy) == '0);
  a_r9_bound: assert property (@(posedge clk) disable iff (rst)
    q_cnt <= QC_W'(QDEPTH));
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    q_overflow |=> q_overflow);
endmodule

// File: tb/flr_handshake_ctrl_tb.sv
module flr_handshake_ctrl_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] pf_flr_lvl = '0;
  logic vf_flr_pulse = 1'b0, drain_ack = 1'b0;
  logic [2:0] vf_flr_pf = '0;
  logic [10:0] vf_flr_off = '0;
  logic drain_req, drain_is_vf, vf_done, q_overflow;
  logic [2:0] drain_pf, vf_done_pf;
  logic [10:0] drain_off, vf_done_off;
  logic [7:0] pf_done, pf_busy;

  flr_handshake_ctrl u_dut (
    .clk(clk), .rst(rst), .pf_flr_lvl(pf_flr_lvl),
    .vf_flr_pulse(vf_flr_pulse), .vf_flr_pf(vf_flr_pf), .vf_flr_off(vf_flr_off),
    .drain_req(drain_req), .drain_is_vf(drain_is_vf), .drain_pf(drain_pf),
    .drain_off(drain_off), .drain_ack(drain_ack), .pf_done(pf_done),
    .vf_done(vf_done), .vf_done_pf(vf_done_pf), .vf_done_off(vf_done_off),
    .pf_busy(pf_busy), .q_overflow(q_overflow));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;
  bit [13:0] mq[$];
  bit [7:0] m_served = '0, exp_pf_done = '0;
  bit m_ovf = 1'b0, st_push = 1'b0, prev_drain = 1'b0, tvf = 1'b0;
  bit [13:0] st_ent = '0, vf_exp = '0;
  bit [2:0] tpf = '0;
  bit [10:0] toff = '0;
  int vf_due = -1, last_vf = -100;
  int ack_pct = 30, vf_pct = 15, rise_pct = 3, drop_pct = 20;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest(input bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic step();
    bit [7:0] pend;
    @(negedge clk);
    cyc++;
    if (drain_req && !prev_drain) begin
      pend = pf_flr_lvl & ~m_served;
      if (pend != 0) begin
        chk(!drain_is_vf, "R2", "drain kind", drain_is_vf, 0);
        chk(drain_pf == 3'(lowest(pend)), "R2", "pf chosen", drain_pf, lowest(pend));
        tvf = 1'b0; tpf = 3'(lowest(pend)); toff = '0;
      end else if (mq.size() > 0) begin
        chk(drain_is_vf, "R3", "drain kind", drain_is_vf, 1);
        chk({drain_pf, drain_off} == mq[0], "R3", "queue order tag",
            {drain_pf, drain_off}, mq[0]);
        tvf = 1'b1; {tpf, toff} = mq[0];
        void'(mq.pop_front());
      end else chk(0, "R2", "drain with nothing pending", 1, 0);
    end
    chk(pf_done == exp_pf_done, "R5", "pf_done", pf_done, exp_pf_done);
    exp_pf_done = '0;
    chk(vf_done == (vf_due == cyc), "R6", "vf_done timing", vf_done, vf_due == cyc);
    if (vf_done) begin
      chk(cyc - last_vf >= 4, "R7", "vf_done spacing", cyc - last_vf, 4);
      chk({vf_done_pf, vf_done_off} == vf_exp, "R6", "vf_done tag",
          {vf_done_pf, vf_done_off}, vf_exp);
      last_vf = cyc; vf_due = -1;
    end
    m_served = (m_served & pf_flr_lvl) | pf_done;
    chk(pf_busy == (pf_flr_lvl & ~m_served), "R8", "pf_busy", pf_busy,
        pf_flr_lvl & ~m_served);
    if (st_push) begin
      if (mq.size() < 8) mq.push_back(st_ent);
      else m_ovf = 1'b1;
    end
    chk(q_overflow == m_ovf, "R9", "overflow flag", q_overflow, m_ovf);
    prev_drain = drain_req;
    if (drain_ack) drain_ack = 1'b0;
    else if (drain_req && ($urandom % 100) < ack_pct) begin
      drain_ack = 1'b1;
      if (!tvf) exp_pf_done = 8'(1) << tpf;
      else begin
        vf_due = (cyc + 1 > last_vf + 4) ? cyc + 1 : last_vf + 4;
        vf_exp = {tpf, toff};
      end
    end
    for (int i = 0; i < 8; i++) begin
      if (pf_flr_lvl[i] && m_served[i] && ($urandom % 100) < drop_pct)
        pf_flr_lvl[i] = 1'b0;
      else if (!pf_flr_lvl[i] && !m_served[i] && ($urandom % 100) < rise_pct)
        pf_flr_lvl[i] = 1'b1;
    end
    st_push = (($urandom % 100) < vf_pct);
    st_ent = 14'($urandom);
    vf_flr_pulse = st_push;
    {vf_flr_pf, vf_flr_off} = st_ent;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
    if (!finished) begin
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!drain_req && pf_done == 0 && !vf_done && !q_overflow, "R1",
        "outputs in reset", {drain_req, pf_done, vf_done, q_overflow}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!drain_req && pf_done == 0 && !vf_done && !q_overflow, "R1",
        "outputs after reset", {drain_req, pf_done, vf_done, q_overflow}, 0);
    prev_drain = drain_req;
    // directed: several PFs together with queued VFs (R2, R3)
    ack_pct = 0; rise_pct = 0; vf_pct = 100;
    repeat (3) step();
    vf_pct = 0; pf_flr_lvl = 8'b0110_0100;
    ack_pct = 100;
    repeat (60) step();
    // random mix, short and long acknowledge delays (R2-R8)
    ack_pct = 30; rise_pct = 3; vf_pct = 15;
    repeat (3000) step();
    ack_pct = 100; vf_pct = 25;
    repeat (1000) step();
    // directed overflow burst with acknowledges withheld (R9)
    ack_pct = 0; rise_pct = 0; vf_pct = 100;
    repeat (14) step();
    vf_pct = 0; ack_pct = 100;
    repeat (300) step();
    chk(q_overflow, "R9", "overflow flag held", q_overflow, 1);
    ack_pct = 40; rise_pct = 3; vf_pct = 20;
    repeat (1500) step();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule